// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits in an audio controller and feeds a codec link with 32-bit command words. Software keeps the commands in a circular buffer in memory. The buffer has 256 slots of one word each. Software writes a command into the slot after its write pointer and then publishes the new write pointer. While it is enabled, the engine reads every slot from its own read pointer plus one up to the published index. It issues one memory read per slot, passes each returned word to the link, and moves its read pointer forward once the link has taken the word.

Software controls the engine through a small register window. One register holds the buffer base address. Others hold the write pointer, the read pointer together with its reset flag, and the run control. A read-only register gives the ring size code. Software clears the read pointer with a two-step exchange. It writes the reset flag, reads the flag back as set, then writes zero and reads the pointer back as zero. Software judges the ring full when the write pointer plus one equals the read pointer, so one slot is always left unused. When the controller is powered down, every register read returns all ones.

Top module: `cmdring_dma`

## Requirements
- R1: After reset, the base, write pointer, read pointer and control registers read zero, and no memory request or command output is valid.
- R2: The size register (index 4) reads 0x02, the code for a 256-slot ring.
- R3: With run set and the read pointer not equal to the write pointer, the engine requests slot (read pointer + 1) mod 256 at address base + 4 × slot. It keeps fetching until the read pointer equals the write pointer.
- R4: Each returned word appears unchanged on cmd_data, and cmd_codec carries its top 4 bits.
- R5: The read pointer (register index 2, bits 7:0) advances by one only when the link accepts a command. With the pointers equal, the engine issues no request.
- R6: Writing register 2 with bit 15 set clears the read pointer and makes bit 15 read 1. While bit 15 is set, fetching is suspended. Writing register 2 with bit 15 clear makes bit 15 read 0, and fetching resumes.
- R7: Clearing the run bit (register 3, bit 0) stops new fetches. The run bit reads 1 until the entry in flight has been delivered, then reads 0.
- R8: While pwr_down is high, every register read returns 0xFFFFFFFF and every register write is ignored.
- R9: A memory request holds its valid and address until it is accepted, and a command holds its valid and data until it is accepted.
- R10: The read pointer wraps from 255 to 0, and slot 0 is fetched from the base address itself.
- R11: With the run bit clear, no fetch starts, even if the pointers differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Controller powered down; reads return all ones |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register index for writes (0 base, 1 write ptr, 2 read ptr, 3 control) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register index for reads (4 = size) |
| reg_rd_data | output | 32 | Register read data, combinational |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the slot |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Command word valid toward the link |
| cmd_ready | input | 1 | Link accepts the command |
| cmd_data | output | 32 | Command word |
| cmd_codec | output | 4 | Target codec address from the word's top bits |

## Verification
The fetch path is driven from a table of ring setups. Each setup changes the base address, the command count, the memory accept gap, the response latency and the link back-pressure. Each one shows whether addresses stay correct when the base sits near an alignment edge, and whether a stall at any stage loses, duplicates or reorders a command. Directed cases follow. A long run crosses slot 255 into slot 0, which separates a correct modulo wrap from an off-by-one in the slot index. A pointer reset with the run bit already set shows that the reset flag, and not the run bit alone, holds the engine back. A stop while a response is outstanding separates "run reads back until halted" from a bit that simply echoes the last write. Writes made during power-down are read back after power-up to show that they were dropped.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

  localparam int unsigned CR_REG_A_W = 3;
  localparam int unsigned CR_REG_W   = 32;

  localparam logic [CR_REG_A_W-1:0] RA_BASE = 3'd0;
  localparam logic [CR_REG_A_W-1:0] RA_WPTR = 3'd1;
  localparam logic [CR_REG_A_W-1:0] RA_RPTR = 3'd2;
  localparam logic [CR_REG_A_W-1:0] RA_CTRL = 3'd3;
  localparam logic [CR_REG_A_W-1:0] RA_SIZE = 3'd4;

  localparam int unsigned RP_RST_BIT = 15;
  localparam int unsigned RUN_BIT    = 0;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_SEND = 2'd3
  } fetch_state_e;

endpackage

// File: rtl/cr_rdptr.sv
module cr_rdptr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_set,
  input  logic             rst_clr,
  input  logic             advance,
  output logic [IDX_W-1:0] rp,
  output logic             rst_flag
);

  function automatic logic [IDX_W-1:0] ptr_step(input logic [IDX_W-1:0] p);
    return p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp       <= '0;
      rst_flag <= 1'b0;
    end else if (rst_set) begin
      rp       <= '0;
      rst_flag <= 1'b1;
    end else begin
      if (rst_clr) rst_flag <= 1'b0;
      if (advance && !rst_flag) rp <= ptr_step(rp);
    end
  end

  // R5: one accepted command moves the pointer by exactly one, modulo the ring
  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !rst_flag && !rst_set) |=> (rp == ($past(rp) + IDX_W'(1))));

  // R5: without a hand-off the pointer does not move
  p_no_drift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !rst_set) |=> $stable(rp));

  // R6: while the reset flag is up the pointer stays at zero
  p_flag_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |-> (rp == '0));

endmodule

// File: rtl/cr_regs.sv
module cr_regs
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned SIZE_CODE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_down,
  input  logic                  wr_en,
  input  logic [CR_REG_A_W-1:0] wr_addr,
  input  logic [CR_REG_W-1:0]   wr_data,
  input  logic [CR_REG_A_W-1:0] rd_addr,
  output logic [CR_REG_W-1:0]   rd_data,
  input  logic [IDX_W-1:0]      rp,
  input  logic                  rp_rst_flag,
  input  logic                  busy,
  output logic [ADDR_W-1:0]     base,
  output logic [IDX_W-1:0]      wp,
  output logic                  run_req,
  output logic                  rp_rst_set,
  output logic                  rp_rst_clr
);

  logic wr_live;
  assign wr_live = wr_en && !pwr_down;

  assign rp_rst_set = wr_live && (wr_addr == RA_RPTR) &&  wr_data[RP_RST_BIT];
  assign rp_rst_clr = wr_live && (wr_addr == RA_RPTR) && !wr_data[RP_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      wp      <= '0;
      run_req <= 1'b0;
    end else if (wr_live) begin
      case (wr_addr)
        RA_BASE: base    <= wr_data[ADDR_W-1:0];
        RA_WPTR: wp      <= wr_data[IDX_W-1:0];
        RA_CTRL: run_req <= wr_data[RUN_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (pwr_down) begin
      rd_data = '1;
    end else begin
      case (rd_addr)
        RA_BASE: rd_data[ADDR_W-1:0] = base;
        RA_WPTR: rd_data[IDX_W-1:0]  = wp;
        RA_RPTR: begin
          rd_data[IDX_W-1:0]  = rp;
          rd_data[RP_RST_BIT] = rp_rst_flag;
        end
        RA_CTRL: rd_data[RUN_BIT] = run_req || busy;
        RA_SIZE: rd_data = CR_REG_W'(SIZE_CODE);
        default: rd_data = '0;
      endcase
    end
  end

  // R8: a powered-down controller keeps its programmed state
  p_pd_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> ($stable(wp) && $stable(base) && $stable(run_req)));

endmodule

// File: rtl/cr_fetch.sv
module cr_fetch
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned CODEC_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_req,
  input  logic               hold,
  input  logic [ADDR_W-1:0]  base,
  input  logic [IDX_W-1:0]   wp,
  input  logic [IDX_W-1:0]   rp,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [DATA_W-1:0]  mem_rsp_data,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [DATA_W-1:0]  cmd_data,
  output logic [CODEC_W-1:0] cmd_codec,
  output logic               busy,
  output logic               advance
);

  localparam int unsigned SLOT_SHIFT = 2;

  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] p);
    return p + IDX_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0]  s);
    return b + ADDR_W'({s, {SLOT_SHIFT{1'b0}}});
  endfunction

  function automatic logic [CODEC_W-1:0] codec_of(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: CODEC_W];
  endfunction

  fetch_state_e     st;
  logic [IDX_W-1:0] slot;
  logic [DATA_W-1:0] word;
  logic             can_start;
  logic             req_fire;

  assign can_start = run_req && !hold && (rp != wp);
  assign req_fire  = (st == FS_REQ) && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FS_IDLE;
      slot <= '0;
      word <= '0;
    end else begin
      case (st)
        FS_IDLE: if (can_start) begin
          st   <= FS_REQ;
          slot <= next_slot(rp);
        end
        FS_REQ:  if (req_fire) st <= FS_WAIT;
        FS_WAIT: if (mem_rsp_valid) begin
          st   <= FS_SEND;
          word <= mem_rsp_data;
        end
        FS_SEND: if (cmd_ready) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == FS_REQ);
  assign mem_req_addr  = slot_addr(base, slot);
  assign cmd_valid     = (st == FS_SEND);
  assign cmd_data      = word;
  assign cmd_codec     = codec_of(word);
  assign busy          = (st != FS_IDLE);
  assign advance       = (st == FS_SEND) && cmd_ready;

  // R9: a pending memory request keeps valid and address until taken
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9: a pending command keeps valid and data until taken
  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R5: equal pointers leave the engine idle
  p_idle_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == FS_IDLE) && (rp == wp)) |=> (st == FS_IDLE));

  // R7/R11: with run clear an idle engine stays idle
  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == FS_IDLE) && !run_req) |=> !mem_req_valid);

  // R6: the pointer-reset flag holds the engine back
  p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == FS_IDLE) && hold) |=> !busy);

endmodule

// File: rtl/cmdring_dma.sv
module cmdring_dma
  import cmdring_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned CODEC_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pwr_down,
  input  logic                  reg_wr_en,
  input  logic [CR_REG_A_W-1:0] reg_wr_addr,
  input  logic [CR_REG_W-1:0]   reg_wr_data,
  input  logic [CR_REG_A_W-1:0] reg_rd_addr,
  output logic [CR_REG_W-1:0]   reg_rd_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  input  logic                  mem_rsp_valid,
  input  logic [DATA_W-1:0]     mem_rsp_data,
  output logic                  cmd_valid,
  input  logic                  cmd_ready,
  output logic [DATA_W-1:0]     cmd_data,
  output logic [CODEC_W-1:0]    cmd_codec
);

  localparam int unsigned SIZE_CODE = (IDX_W == 8) ? 2 : ((IDX_W == 4) ? 1 : 0);

  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  wp;
  logic [IDX_W-1:0]  rp;
  logic              run_req;
  logic              rp_rst_set;
  logic              rp_rst_clr;
  logic              rp_rst_flag;
  logic              busy;
  logic              advance;

  cr_regs #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .SIZE_CODE(SIZE_CODE)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .wr_en      (reg_wr_en),
    .wr_addr    (reg_wr_addr),
    .wr_data    (reg_wr_data),
    .rd_addr    (reg_rd_addr),
    .rd_data    (reg_rd_data),
    .rp         (rp),
    .rp_rst_flag(rp_rst_flag),
    .busy       (busy),
    .base       (base),
    .wp         (wp),
    .run_req    (run_req),
    .rp_rst_set (rp_rst_set),
    .rp_rst_clr (rp_rst_clr)
  );

  cr_rdptr #(
    .IDX_W(IDX_W)
  ) rdptr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_set (rp_rst_set),
    .rst_clr (rp_rst_clr),
    .advance (advance),
    .rp      (rp),
    .rst_flag(rp_rst_flag)
  );

  cr_fetch #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .CODEC_W(CODEC_W)
  ) fetch_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_req      (run_req),
    .hold         (rp_rst_flag),
    .base         (base),
    .wp           (wp),
    .rp           (rp),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_data     (cmd_data),
    .cmd_codec    (cmd_codec),
    .busy         (busy),
    .advance      (advance)
  );

  // R3: the engine only runs while enabled or finishing an entry
  p_run_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_req_valid)) |-> (run_req && !rp_rst_flag));

endmodule

// File: tb/cmdring_dma_tb_top.sv
module cmdring_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_down = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [2:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_data;
  logic [3:0]  cmd_codec;

  always #2.5 clk = ~clk;

  cmdring_dma dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_codec(cmd_codec)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // environment knobs
  int mem_gap = 0;
  int mem_lat = 0;
  int snk_gap = 0;

  // logs
  logic [31:0] rec_addr [0:511];
  logic [31:0] rec_data [0:511];
  logic [3:0]  rec_codec [0:511];
  int req_cnt = 0;
  int cmd_cnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[5:2] ^ 4'h3, 4'hC, a[23:0]};
  endfunction

  // memory responder
  initial begin
    int wait_n;
    int rsp_cnt;
    logic [31:0] rsp_addr;
    wait_n = 0; rsp_cnt = 0; rsp_addr = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(rsp_addr);
        end
      end
      if (mem_req_valid) begin
        mem_req_ready = (wait_n >= mem_gap);
        wait_n++;
        if (mem_req_ready) begin
          if (req_cnt < 512) rec_addr[req_cnt] = mem_req_addr;
          req_cnt++;
          rsp_addr = mem_req_addr;
          rsp_cnt  = mem_lat + 1;
          wait_n   = 0;
        end
      end else begin
        mem_req_ready = 1'b0;
        wait_n = 0;
      end
    end
  end

  // link sink
  initial begin
    int wait_n;
    wait_n = 0;
    cmd_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        cmd_ready = (wait_n >= snk_gap);
        wait_n++;
        if (cmd_ready) begin
          if (cmd_cnt < 512) begin
            rec_data[cmd_cnt]  = cmd_data;
            rec_codec[cmd_cnt] = cmd_codec;
          end
          cmd_cnt++;
          wait_n = 0;
        end
      end else begin
        cmd_ready = 1'b0;
        wait_n = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_rd_addr = a;
    #1 v = reg_rd_data;
  endtask

  task automatic wait_rp(input logic [7:0] target);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd2, v);
      if (v[7:0] == target) break;
    end
  endtask

  task automatic ptr_reset();
    wr(3'd2, 32'h0000_8000);
    wr(3'd2, 32'h0);
  endtask

  task automatic clear_logs();
    req_cnt = 0;
    cmd_cnt = 0;
  endtask

  // stimulus table: base, count, accept gap, response latency, sink gap
  localparam int NVEC = 5;
  localparam logic [51:0] VEC [0:NVEC-1] = '{
    {32'h0000_1000, 8'd4,  4'd0, 4'd0, 4'd0},
    {32'h0002_0400, 8'd7,  4'd2, 4'd1, 4'd0},
    {32'h8000_0000, 8'd3,  4'd0, 4'd3, 4'd2},
    {32'hFFFF_FF00, 8'd5,  4'd1, 4'd0, 4'd1},
    {32'h0000_3FFC, 8'd12, 4'd3, 4'd2, 4'd3}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] b;
    logic [7:0]  n;
    bit ok_a, ok_d, ok_c;
    int bad;
    int saved;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(3'd0, v); chk(v == 32'h0, "R1 base", v, 32'h0);
    rd(3'd1, v); chk(v == 32'h0, "R1 wptr", v, 32'h0);
    rd(3'd2, v); chk(v == 32'h0, "R1 rptr", v, 32'h0);
    rd(3'd3, v); chk(v == 32'h0, "R1 ctrl", v, 32'h0);
    chk(!mem_req_valid && !cmd_valid, "R1 outputs idle", {30'b0, mem_req_valid, cmd_valid}, 32'h0);
    // R2: size code
    rd(3'd4, v); chk(v == 32'h2, "R2 size", v, 32'h2);

    // table-driven fetch runs: R3, R4, R5, R9
    for (int k = 0; k < NVEC; k++) begin
      b = VEC[k][51:20];
      n = VEC[k][19:12];
      wr(3'd3, 32'h0);
      ptr_reset();
      wr(3'd1, 32'h0);
      wr(3'd0, b);
      mem_gap = int'(VEC[k][11:8]);
      mem_lat = int'(VEC[k][7:4]);
      snk_gap = int'(VEC[k][3:0]);
      clear_logs();
      wr(3'd3, 32'h1);
      wr(3'd1, {24'b0, n});
      wait_rp(n);
      repeat (10) @(negedge clk);
      chk(req_cnt == int'(n), "R5 request count", req_cnt, {24'b0, n});
      chk(cmd_cnt == int'(n), "R4 command count", cmd_cnt, {24'b0, n});
      rd(3'd2, v); chk(v[7:0] == n, "R5 read pointer settles on write pointer", v, {24'b0, n});
      ok_a = 1; ok_d = 1; ok_c = 1; bad = 0;
      for (int j = 0; j < int'(n); j++) begin
        if (rec_addr[j] != b + 32'(4 * (j + 1))) begin ok_a = 0; bad = j; end
        if (rec_data[j] != mem_word(b + 32'(4 * (j + 1)))) ok_d = 0;
        if (rec_codec[j] != mem_word(b + 32'(4 * (j + 1)))[31:28]) ok_c = 0;
      end
      chk(ok_a, "R3 slot addresses", rec_addr[bad], b + 32'(4 * (bad + 1)));
      chk(ok_d, "R4 command words", 32'(ok_d), 32'h1);
      chk(ok_c, "R4 codec field", 32'(ok_c), 32'h1);
    end
    mem_gap = 0; mem_lat = 0; snk_gap = 0;

    // R10: wrap past slot 255
    wr(3'd3, 32'h0);
    ptr_reset();
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0010_0000);
    wr(3'd3, 32'h1);
    wr(3'd1, 32'd250);
    wait_rp(8'd250);
    clear_logs();
    wr(3'd1, 32'd3);
    wait_rp(8'd3);
    repeat (5) @(negedge clk);
    chk(cmd_cnt == 9, "R10 entries across wrap", cmd_cnt, 32'd9);
    chk(rec_addr[4] == 32'h0010_03FC, "R10 slot 255 address", rec_addr[4], 32'h0010_03FC);
    chk(rec_addr[5] == 32'h0010_0000, "R10 slot 0 at base", rec_addr[5], 32'h0010_0000);
    chk(rec_addr[8] == 32'h0010_000C, "R10 slot 3 address", rec_addr[8], 32'h0010_000C);

    // R11: run clear, pointers differ
    wr(3'd3, 32'h0);
    ptr_reset();
    wr(3'd1, 32'h0);
    clear_logs();
    wr(3'd1, 32'd5);
    repeat (30) @(negedge clk);
    chk(req_cnt == 0, "R11 no fetch while stopped", req_cnt, 32'h0);

    // R6: pointer reset handshake with run set
    wr(3'd2, 32'h0000_8000);
    rd(3'd2, v); chk(v == 32'h0000_8000, "R6 flag reads set, pointer zero", v, 32'h0000_8000);
    wr(3'd3, 32'h1);
    repeat (30) @(negedge clk);
    chk(req_cnt == 0, "R6 fetch held by reset flag", req_cnt, 32'h0);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk(v[15] == 1'b0, "R6 flag reads clear", v, 32'h0);
    wait_rp(8'd5);
    chk(req_cnt == 5, "R6 fetch resumes after clear", req_cnt, 32'd5);

    // R7: stop with an entry in flight
    mem_lat = 20;
    snk_gap = 0;
    clear_logs();
    wr(3'd1, 32'd6);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_cnt > 0) break;
    end
    wr(3'd3, 32'h0);
    rd(3'd3, v); chk(v == 32'h1, "R7 run reads set until halted", v, 32'h1);
    rd(3'd2, v); chk(v[7:0] == 8'd5, "R5 pointer waits for hand-off", v, 32'd5);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cmd_cnt > 0) break;
    end
    repeat (3) @(negedge clk);
    rd(3'd3, v); chk(v == 32'h0, "R7 run reads clear after halt", v, 32'h0);
    rd(3'd2, v); chk(v[7:0] == 8'd6, "R7 in-flight entry delivered", v, 32'd6);
    mem_lat = 0;
    wr(3'd1, 32'd9);
    saved = req_cnt;
    repeat (40) @(negedge clk);
    chk(req_cnt == saved, "R7 no new fetch after stop", req_cnt, saved);
    wr(3'd3, 32'h1);
    wait_rp(8'd9);
    chk(cmd_cnt == 4, "R7 resume delivers the rest", cmd_cnt, 32'd4);

    // R8: power down
    wr(3'd3, 32'h0);
    repeat (5) @(negedge clk);
    pwr_down = 1'b1;
    rd(3'd2, v); chk(v == 32'hFFFF_FFFF, "R8 pointer reads all ones", v, 32'hFFFF_FFFF);
    rd(3'd4, v); chk(v == 32'hFFFF_FFFF, "R8 size reads all ones", v, 32'hFFFF_FFFF);
    wr(3'd1, 32'h77);
    wr(3'd0, 32'h1234_5670);
    pwr_down = 1'b0;
    rd(3'd1, v); chk(v == 32'd9, "R8 write pointer write dropped", v, 32'd9);
    rd(3'd0, v); chk(v == 32'h0010_0000, "R8 base write dropped", v, 32'h0010_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule